// File: doc/BRIEF.md
# Grid-synchronised sine reference generator

This block produces a sinusoidal current reference that follows the phase and frequency of the mains voltage. The grid voltage arrives as a square wave from an external zero-crossing comparator. The block resynchronises and debounces that square wave. It measures the time between accepted rising edges with a free-running counter, and a serial divider turns each plausible period into a phase step. A phase accumulator adds that step every clock, so it walks once round a sine table in each grid cycle.

Each accepted rising edge forces the accumulator back to zero phase. This keeps the reference aligned with the grid, even while the step size is still settling. The table value is scaled by an amplitude command from the power-tracking stage, and the result is the current reference for the inverter's current loop. A lock flag reports when the measured grid period has been plausible for several cycles in a row.

The nominal period is given in clock cycles by a parameter: for a 50 Hz grid it equals the clock frequency divided by 50.

Top module: `grid_sine_ref`

## Requirements
- R1: While reset is held, `refCurrent` is 0 and `locked` is 0.
- R2: The grid input passes through two synchroniser flops. A rising edge is accepted only once the synchronised level has been high for 8 consecutive clocks, so a high pulse of fewer than 8 clocks neither realigns the phase nor counts as a period.
- R3: An accepted rising edge zeroes the 32-bit phase accumulator. If the input pin rises just before clock edge k, the accumulator is 0 after edge k+10, and after edge k+10+n it is n times the increment, modulo 2^32.
- R4: The measured period P is the number of clocks between two accepted rising edges. If P lies within plus or minus 10% of NOM_PERIOD (integer limits NOM_PERIOD - NOM_PERIOD/10 and NOM_PERIOD + NOM_PERIOD/10, both inclusive), the phase increment becomes floor(2^32 / P) within 40 clocks.
- R5: A measured period outside those limits leaves the increment unchanged. The accepted edge still realigns the phase.
- R6: After reset, the increment is floor(2^32 / NOM_PERIOD).
- R7: `locked` is 1 after three consecutive in-range periods. It drops to 0 on an out-of-range period, and also when no accepted edge arrives within NOM_PERIOD + NOM_PERIOD/10 clocks.
- R8: The sine table has 256 signed 16-bit entries. Entry k is round(32767 * sin(2*pi*k/256)), with halves rounded away from zero. The table is indexed by bits 31:24 of the phase accumulator.
- R9: `refCurrent` is the table entry times the unsigned `ampCmd`, shifted right arithmetically by 16. The table read and the multiply are each registered, so the value in `refCurrent` after edge m comes from the phase held after edge m-2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| gridSqIn | input | 1 | Asynchronous square wave from the grid zero-crossing comparator |
| ampCmd | input | 16 | Unsigned amplitude command from the power tracker |
| refCurrent | output | 16 | Signed sinusoidal current reference |
| locked | output | 1 | Grid period has been in range for three consecutive cycles |

## Verification
Phase realignment and period rejection act on the same clock edge. The rising edge that ends an out-of-range period must still zero the accumulator, while the increment stays as it was and the lock drops. The bench provokes this with a period one clock above the upper limit. It judges the result from the reference value a few hundred clocks after that edge, computed from zero phase and the earlier increment, and from the lock flag in the same period. A glitch placed in the low half of a cycle tests the other side: the debounce must keep a false edge from realigning the phase.

// File: rtl/gsr_pkg.sv
package gsr_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic clrPhase;  // accepted rising edge: realign phase to zero
    logic divStart;  // in-range period measured: recompute increment
  } ctrlStrobes_t;
endpackage

// File: rtl/gsr_edge_filter.sv
module gsr_edge_filter #(
  parameter int STABLE_CLKS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic rawIn,
  output logic riseAcc
);
  logic syncA, syncLvl;
  logic [STABLE_CLKS-1:0] hist;
  logic filtLvl;
  logic allHigh, allLow;

  assign allHigh = &hist;
  assign allLow  = ~|hist;
  assign riseAcc = allHigh & ~filtLvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      syncA   <= 1'b0;
      syncLvl <= 1'b0;
      hist    <= '0;
      filtLvl <= 1'b0;
    end else begin
      syncA   <= rawIn;
      syncLvl <= syncA;
      hist    <= {hist[STABLE_CLKS-2:0], syncLvl};
      if (allHigh)
        filtLvl <= 1'b1;
      else if (allLow)
        filtLvl <= 1'b0;
    end
  end

  // R2: an accepted rise needs the synchronised level high in the cycle before
  a_r2_rise_after_high: assert property (@(posedge clk) disable iff (rst)
    riseAcc |-> $past(syncLvl));
endmodule

// File: rtl/gsr_ctrl.sv
module gsr_ctrl
  import gsr_pkg::*;
#(
  parameter int CNT_W     = 22,
  parameter int MIN_P     = 1800000,
  parameter int MAX_P     = 2200000,
  parameter int LOCK_RUNS = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           riseAcc,
  output ctrlStrobes_t   strobes,
  output logic [CNT_W:0] measPeriod,
  output logic           locked
);
  localparam int PW    = CNT_W + 1;
  localparam int RUN_W = $clog2(LOCK_RUNS + 1);

  logic [CNT_W-1:0] sinceRise;
  logic             havePrev;
  logic [RUN_W-1:0] validRun;
  logic             inRange;
  logic             overdue;

  assign measPeriod = {1'b0, sinceRise} + PW'(1);
  assign inRange    = (measPeriod >= PW'(MIN_P)) && (measPeriod <= PW'(MAX_P));
  assign overdue    = {1'b0, sinceRise} >= PW'(MAX_P);
  assign locked     = (validRun == RUN_W'(LOCK_RUNS));

  always_comb begin
    strobes.clrPhase = riseAcc;
    strobes.divStart = riseAcc & havePrev & inRange;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sinceRise <= '0;
      havePrev  <= 1'b0;
      validRun  <= '0;
    end else begin
      if (riseAcc)
        sinceRise <= '0;
      else if (sinceRise != '1)
        sinceRise <= sinceRise + CNT_W'(1);

      if (riseAcc) begin
        havePrev <= 1'b1;
        if (havePrev) begin
          if (!inRange)
            validRun <= '0;
          else if (validRun != RUN_W'(LOCK_RUNS))
            validRun <= validRun + RUN_W'(1);
        end
      end else if (overdue) begin
        validRun <= '0;
      end
    end
  end

  // R7: lock can only rise right after an in-range period was measured
  a_r7_lock_after_valid: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(strobes.divStart));
endmodule

// File: rtl/gsr_datapath.sv
module gsr_datapath
  import gsr_pkg::*;
#(
  parameter int PHASE_W    = 32,
  parameter int IDX_W      = 8,
  parameter int SINE_W     = 16,
  parameter int AMP_W      = 16,
  parameter int CNT_W      = 22,
  parameter int NOM_PERIOD = 2000000,
  parameter int MIN_P      = 1800000,
  parameter int MAX_P      = 2200000
) (
  input  logic                     clk,
  input  logic                     rst,
  input  ctrlStrobes_t             strobes,
  input  logic [CNT_W:0]           measPeriod,
  input  logic [AMP_W-1:0]         ampCmd,
  output logic signed [SINE_W-1:0] refCurrent
);
  localparam int DIV_W  = CNT_W + 1;
  localparam int STEPS  = PHASE_W + 1;
  localparam int STEP_W = $clog2(STEPS + 1);
  localparam int DEPTH  = 1 << IDX_W;
  localparam int PROD_W = SINE_W + AMP_W + 1;
  localparam logic [PHASE_W-1:0] NOM_INC = PHASE_W'((64'd1 << PHASE_W) / 64'(NOM_PERIOD));
  localparam logic [PHASE_W-1:0] INC_LO  = PHASE_W'((64'd1 << PHASE_W) / 64'(MAX_P));
  localparam logic [PHASE_W-1:0] INC_HI  = PHASE_W'((64'd1 << PHASE_W) / 64'(MIN_P));
  localparam real TWO_PI = 6.283185307179586;
  localparam real PEAK   = real'((1 << (SINE_W - 1)) - 1);

  // Serial restoring divider: 2^PHASE_W / measured period
  logic [DIV_W-1:0]  divisor, rem;
  logic [PHASE_W:0]  dvd, quot;
  logic [STEP_W-1:0] stepsLeft;
  logic              divBusy, divDone;
  logic [DIV_W:0]    trial;
  logic              fits;

  assign trial = {rem, dvd[PHASE_W]};
  assign fits  = trial >= {1'b0, divisor};

  always_ff @(posedge clk) begin
    if (rst) begin
      divisor   <= '0;
      rem       <= '0;
      dvd       <= '0;
      quot      <= '0;
      stepsLeft <= '0;
      divBusy   <= 1'b0;
      divDone   <= 1'b0;
    end else begin
      divDone <= 1'b0;
      if (strobes.divStart) begin
        divisor   <= measPeriod;
        rem       <= '0;
        dvd       <= {1'b1, {PHASE_W{1'b0}}};
        quot      <= '0;
        stepsLeft <= STEP_W'(STEPS);
        divBusy   <= 1'b1;
      end else if (divBusy) begin
        rem       <= fits ? DIV_W'(trial - {1'b0, divisor}) : trial[DIV_W-1:0];
        quot      <= {quot[PHASE_W-1:0], fits};
        dvd       <= {dvd[PHASE_W-1:0], 1'b0};
        stepsLeft <= stepsLeft - STEP_W'(1);
        if (stepsLeft == STEP_W'(1)) begin
          divBusy <= 1'b0;
          divDone <= 1'b1;
        end
      end
    end
  end

  // Increment register and phase accumulator
  logic [PHASE_W-1:0] incReg, phaseAcc;

  always_ff @(posedge clk) begin
    if (rst) begin
      incReg   <= NOM_INC;
      phaseAcc <= '0;
    end else begin
      if (divDone)
        incReg <= PHASE_W'(quot);
      if (strobes.clrPhase)
        phaseAcc <= '0;
      else
        phaseAcc <= phaseAcc + incReg;
    end
  end

  // Sine table computed at elaboration
  logic signed [SINE_W-1:0] romArr [DEPTH];
  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_rom
    localparam real VAL  = PEAK * $sin(TWO_PI * real'(gi) / real'(DEPTH));
    localparam int  IVAL = (VAL >= 0.0) ? $rtoi(VAL + 0.5) : -$rtoi(0.5 - VAL);
    assign romArr[gi] = SINE_W'(IVAL);
  end

  logic signed [SINE_W-1:0] sineReg;
  logic signed [PROD_W-1:0] prod, scaled;

  assign prod   = sineReg * $signed({1'b0, ampCmd});
  assign scaled = prod >>> AMP_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      sineReg    <= '0;
      refCurrent <= '0;
    end else begin
      sineReg    <= romArr[phaseAcc[PHASE_W-1 -: IDX_W]];
      refCurrent <= SINE_W'(scaled);
    end
  end

  // R4: a finished division of an in-range period lands in the plausible band
  a_r4_inc_in_band: assert property (@(posedge clk) disable iff (rst)
    divDone |-> (PHASE_W'(quot) >= INC_LO) && (PHASE_W'(quot) <= INC_HI));
  // R5: increment only moves after a completed division
  a_r5_inc_hold: assert property (@(posedge clk) disable iff (rst)
    !divDone |=> $stable(incReg));
  // R9: zero amplitude gives zero reference
  a_r9_zero_amp: assert property (@(posedge clk) disable iff (rst)
    ($past(ampCmd) == '0) |-> (refCurrent == '0));
endmodule

// File: rtl/grid_sine_ref.sv
module grid_sine_ref
  import gsr_pkg::*;
#(
  parameter int NOM_PERIOD  = 2000000,
  parameter int STABLE_CLKS = 8,
  parameter int LOCK_RUNS   = 3,
  parameter int PHASE_W     = 32,
  parameter int IDX_W       = 8,
  parameter int SINE_W      = 16,
  parameter int AMP_W       = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     gridSqIn,
  input  logic [AMP_W-1:0]         ampCmd,
  output logic signed [SINE_W-1:0] refCurrent,
  output logic                     locked
);
  localparam int MIN_P = NOM_PERIOD - NOM_PERIOD / 10;
  localparam int MAX_P = NOM_PERIOD + NOM_PERIOD / 10;
  localparam int CNT_W = $clog2(MAX_P + 2);

  logic           riseAcc;
  ctrlStrobes_t   strobes;
  logic [CNT_W:0] measPeriod;

  gsr_edge_filter #(.STABLE_CLKS(STABLE_CLKS)) u_filter (
    .clk(clk), .rst(rst), .rawIn(gridSqIn), .riseAcc(riseAcc)
  );

  gsr_ctrl #(
    .CNT_W(CNT_W), .MIN_P(MIN_P), .MAX_P(MAX_P), .LOCK_RUNS(LOCK_RUNS)
  ) u_ctrl (
    .clk(clk), .rst(rst), .riseAcc(riseAcc), .strobes(strobes),
    .measPeriod(measPeriod), .locked(locked)
  );

  gsr_datapath #(
    .PHASE_W(PHASE_W), .IDX_W(IDX_W), .SINE_W(SINE_W), .AMP_W(AMP_W),
    .CNT_W(CNT_W), .NOM_PERIOD(NOM_PERIOD), .MIN_P(MIN_P), .MAX_P(MAX_P)
  ) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .measPeriod(measPeriod),
    .ampCmd(ampCmd), .refCurrent(refCurrent)
  );
endmodule

// File: tb/grid_sine_ref_bench.sv
`timescale 1ns/1ps
module grid_sine_ref_bench;
  localparam int NOM = 1000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic gridSq = 1'b0;
  logic [15:0] amp = 16'd30000;
  logic signed [15:0] refCur;
  logic locked;
  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  grid_sine_ref #(.NOM_PERIOD(NOM)) u_grid_sine_ref (
    .clk(clk), .rst(rst), .gridSqIn(gridSq), .ampCmd(amp),
    .refCurrent(refCur), .locked(locked)
  );

  function automatic longint incFor(longint p);
    return (64'd1 << 32) / p;
  endfunction

  function automatic longint sineAt(longint k);
    real v;
    v = 32767.0 * $sin(6.283185307179586 * real'(k) / 256.0);
    return (v >= 0.0) ? longint'($rtoi(v + 0.5)) : -longint'($rtoi(0.5 - v));
  endfunction

  function automatic longint expRef(int n, longint inc, longint a);
    longint ph, prod;
    ph   = (longint'(n) * inc) & 64'hFFFF_FFFF;
    prod = sineAt(ph >> 24) * a;
    return prod >>> 16;
  endfunction

  task automatic check(string req, longint act, longint exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One grid period starting at a negedge; optional reference check at
  // offset n after this period's rise, optional short glitch
  task automatic onePeriod(int p, int n, longint inc, string req, int glitchAt = -1);
    gridSq = 1'b1;
    for (int i = 1; i < p; i++) begin
      @(negedge clk);
      if (i == p / 2) gridSq = 1'b0;
      if (glitchAt >= 0 && i == glitchAt) gridSq = 1'b1;
      if (glitchAt >= 0 && i == glitchAt + 5) gridSq = 1'b0;
      if (n >= 0 && i == 13 + n) check(req, refCur, expRef(n, inc, amp));
    end
    @(negedge clk);
  endtask

  task automatic testReset();
    repeat (5) @(negedge clk);
    check("R1 ref in reset", refCur, 0);
    check("R1 lock in reset", locked, 0);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic testNominalAndLock();
    onePeriod(NOM, 64, incFor(NOM), "R6 nominal increment");
    onePeriod(NOM, 0, incFor(NOM), "R3 zero phase after rise");
    onePeriod(NOM, -1, 0, "");
    check("R7 not locked after two periods", locked, 0);
    onePeriod(NOM, 250, incFor(NOM), "R8 table value");
    check("R7 locked after three periods", locked, 1);
  endtask

  task automatic testPeriodChange();
    onePeriod(1100, -1, 0, "");
    onePeriod(1100, -1, 0, "");
    onePeriod(1100, 300, incFor(1100), "R4 upper limit period");
    check("R4 lock held at limit", locked, 1);
  endtask

  task automatic testReject();
    onePeriod(1101, -1, 0, "");
    onePeriod(NOM, 400, incFor(1100), "R5 increment kept, phase realigned");
    check("R5 lock dropped on bad period", locked, 0);
    onePeriod(NOM, -1, 0, "");
    onePeriod(NOM, -1, 0, "");
    onePeriod(NOM, -1, 0, "");
    check("R7 relocked", locked, 1);
  endtask

  task automatic testGlitch();
    onePeriod(NOM, 750, incFor(NOM), "R2 short pulse ignored", 700);
    check("R2 lock kept through glitch", locked, 1);
  endtask

  task automatic testAmplitude();
    amp = 16'd0;
    onePeriod(NOM, 200, incFor(NOM), "R9 zero amplitude");
    amp = 16'hFFFF;
    onePeriod(NOM, 700, incFor(NOM), "R9 full amplitude negative half");
  endtask

  task automatic testTimeout();
    gridSq = 1'b0;
    repeat (1200) @(negedge clk);
    check("R7 lock lost on missing edge", locked, 0);
  endtask

  initial begin
    testReset();
    testNominalAndLock();
    testPeriodChange();
    testReject();
    testGlitch();
    testAmplitude();
    testTimeout();
    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end
endmodule